// File: doc/BRIEF.md
# Conflict Sensing Retry Monitor

This block watches a group of requesters that compete for one shared output resource and reports contention that does not go away. A single slot timer watches one active requester at a time. If that requester gets no grant within a programmable number of cycles, its slot fails: the request is marked pending, its failed-try count goes up by one, and the watch moves on to the next active requester in rotating order. Once a requester has failed a programmable number of slots in a row, the block sends a one-cycle reconfiguration pulse to the configuration controller, together with the index of that requester.

While any request is pending, a conflict level is held high. The arbiter can use it to decide whether a lower class of traffic should temporarily inherit a higher priority. A grant, or a dropped request, clears that requester's pending flag and its count. The slot length and the retry limit sit in registers that the configuration controller can load at any time.

Top module: `conflict_sense_monitor`

## Requirements
- R1: During and directly after reset, `pend_o`, `conflict_o` and `reconf_o` are 0 and `reconf_idx_o` is 0.
- R2: A requester that is watched for L cycles without a grant fails its slot, and its `pend_o` bit goes high after that edge. After reset the watch starts at requester 0. So with a lone request, requester 0 first fails on the L-th sampling edge and any other requester on edge L+1, because one edge is spent moving the watch.
- R3: When a slot fails, or when the watched requester is not active (not requesting, or being granted), the watch moves to the next active requester in ascending index order, wrapping around. A lone active requester is watched again at once, so its failures come every L cycles.
- R4: Each failed slot adds one to that requester's count. The slot that brings the count to the limit M raises `reconf_o` for exactly one cycle, right after that edge, and the count restarts from zero while the request stays pending.
- R5: A grant, or a low `req_i` bit, clears that requester's pending flag and count on the next edge. A grant that arrives on the edge where the slot would expire prevents the failure, and a fresh slot of L cycles starts.
- R6: `conflict_o` is high exactly when at least one `pend_o` bit is high.
- R7: A high `cfg_wr_i` loads the slot length from `cfg_slot_i` and the limit from `cfg_limit_i`, and both take effect from the next edge. A value of 0 in either field behaves as 1.
- R8: Reset loads a slot length of DEF_SLOT (16) and a limit of DEF_LIMIT (4).
- R9: `reconf_idx_o` carries the binary index of the requester that caused the pulse. It is valid in the pulse cycle and holds that value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_REQ | Request bits, one per requester |
| gnt_i | input | N_REQ | Grant bits from the arbiter |
| cfg_wr_i | input | 1 | Load strobe for slot length and limit |
| cfg_slot_i | input | SLOT_W | New slot length in cycles |
| cfg_limit_i | input | CNT_W | New number of failed slots that triggers reconfiguration |
| pend_o | output | N_REQ | Pending flag per requester |
| conflict_o | output | 1 | High while any request is pending |
| reconf_o | output | 1 | One-cycle reconfiguration request |
| reconf_idx_o | output | $clog2(N_REQ) | Index of the requester that triggered `reconf_o` |

## Verification
A grant and a slot expiry can fall on the same edge for the watched requester. The bench provokes this by raising the grant exactly on the edge where the L-th cycle of the slot ends. It then expects the pending flag to stay low on that edge and to rise only L cycles later. The bench also places a grant in the middle of a run of failures. It judges the outcome by the later position of the first failure and of the reconfiguration pulse, both computed from L and M.

// File: rtl/csm_pkg.sv
// Shared helpers for the conflict sensing retry monitor.
// Assumes: callers pass a modulus greater than zero.
package csm_pkg;

    // Step an index forward by a given amount, wrapping at n.
    function automatic int unsigned wrap_add(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/cs_slot_watch.sv
// Slot watcher: one timer watches one active requester at a time.
// A slot fails when the watched requester stays active with no grant
// for slot_last_i+1 cycles. After a failure, or when the watched
// requester is not active, the watch rotates to the next active one.
// Assumes: active_i is already masked with the grant, and N_REQ >= 2.
module cs_slot_watch #(
    parameter int N_REQ  = 4,
    parameter int SLOT_W = 8,
    localparam int IDX_W = $clog2(N_REQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  active_i,
    input  logic [SLOT_W-1:0] slot_last_i,
    output logic              fail_o,
    output logic [IDX_W-1:0]  fail_idx_o
);
    import csm_pkg::*;

    logic [IDX_W-1:0]  cur_q;
    logic [SLOT_W-1:0] tmr_q;
    logic [IDX_W-1:0]  nxt_idx;
    logic              nxt_found;
    logic              expire;

    // Find the first active requester after the current one, wrapping.
    always_comb begin
        int unsigned cand;
        nxt_found = 1'b0;
        nxt_idx   = cur_q;
        for (int k = 1; k <= N_REQ; k++) begin
            cand = wrap_add(int'(cur_q), k, N_REQ);
            if (!nxt_found && active_i[cand]) begin
                nxt_found = 1'b1;
                nxt_idx   = IDX_W'(cand);
            end
        end
    end

    // The slot expires once the watched requester has waited the full length.
    assign expire = active_i[cur_q] && (tmr_q >= slot_last_i);

    // Advance the slot timer and rotate the watch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            tmr_q <= '0;
        end else if (!active_i[cur_q] || expire) begin
            tmr_q <= '0;
            if (nxt_found) cur_q <= nxt_idx;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    assign fail_o     = expire;
    assign fail_idx_o = cur_q;

    // R2
    restart_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> tmr_q == '0);

    // R3
    rotate_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && $countones(active_i) > 1) |=> cur_q != $past(cur_q));

endmodule

// File: rtl/cs_try_count.sv
// Failed-try counter for one requester. It counts failed slots, holds
// the pending flag, and reports a hit when a failure reaches the limit.
// Assumes: clr_i and fail_i are never high together (a failure needs
// an active request, and clr_i marks a requester that is not active).
module cs_try_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fail_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             pend_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    // The failure that brings the count to the limit is a hit.
    assign hit_o = fail_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i});

    // Update the count and pending flag from clears and failed slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (fail_i) begin
            pend_q <= 1'b1;
            cnt_q  <= hit_o ? '0 : cnt_q + 1'b1;
        end
    end

    assign pend_o = pend_q;

    // R4
    restart_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> cnt_q == '0);

    // R5
    clear_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!pend_q && cnt_q == '0));

    // R2
    pend_needs_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !fail_i) |=> !pend_q);

endmodule

// File: rtl/cs_reconf_out.sv
// Reconfiguration request stage. It turns the per-requester hit
// strobes into a registered one-cycle pulse plus a binary index.
// Assumes: at most one hit per cycle, because one slot is watched at a time.
module cs_reconf_out #(
    parameter int N_REQ = 4,
    localparam int IDX_W = $clog2(N_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] hit_i,
    output logic             pulse_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] enc;
    logic             pulse_q;
    logic [IDX_W-1:0] idx_q;

    // Encode the hit vector into a binary index.
    always_comb begin
        enc = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (hit_i[i]) enc = IDX_W'(i);
        end
    end

    // Register the pulse and keep the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            pulse_q <= |hit_i;
            if (|hit_i) idx_q <= enc;
        end
    end

    assign pulse_o = pulse_q;
    assign idx_o   = idx_q;

    // R9
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_i));

endmodule

// File: rtl/conflict_sense_monitor.sv
// Top of the conflict sensing retry monitor. It holds the runtime
// slot length and limit registers, masks requests with grants, and
// connects the slot watcher, one try counter per requester, and the
// reconfiguration output stage.
// Assumes: grants come from an external arbiter; requests stay high
// until they are granted or withdrawn.
module conflict_sense_monitor #(
    parameter int N_REQ     = 4,
    parameter int SLOT_W    = 8,
    parameter int CNT_W     = 4,
    parameter int DEF_SLOT  = 16,
    parameter int DEF_LIMIT = 4,
    localparam int IDX_W    = $clog2(N_REQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  req_i,
    input  logic [N_REQ-1:0]  gnt_i,
    input  logic              cfg_wr_i,
    input  logic [SLOT_W-1:0] cfg_slot_i,
    input  logic [CNT_W-1:0]  cfg_limit_i,
    output logic [N_REQ-1:0]  pend_o,
    output logic              conflict_o,
    output logic              reconf_o,
    output logic [IDX_W-1:0]  reconf_idx_o
);
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  limit_q;
    logic [SLOT_W-1:0] slot_last;
    logic [CNT_W-1:0]  limit_eff;
    logic [N_REQ-1:0]  active;
    logic [N_REQ-1:0]  pend;
    logic [N_REQ-1:0]  hit;
    logic              fail;
    logic [IDX_W-1:0]  fail_idx;

    // Runtime configuration registers, loaded by the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SLOT_W'(DEF_SLOT);
            limit_q <= CNT_W'(DEF_LIMIT);
        end else if (cfg_wr_i) begin
            slot_q  <= cfg_slot_i;
            limit_q <= cfg_limit_i;
        end
    end

    // A zero in either field behaves as one.
    assign slot_last = (slot_q == '0) ? '0 : slot_q - 1'b1;
    assign limit_eff = (limit_q == '0) ? CNT_W'(1) : limit_q;
    assign active    = req_i & ~gnt_i;

    cs_slot_watch #(.N_REQ(N_REQ), .SLOT_W(SLOT_W)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .slot_last_i(slot_last),
        .fail_o     (fail),
        .fail_idx_o (fail_idx)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_cnt
        cs_try_count #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (!active[g]),
            .fail_i (fail && (fail_idx == IDX_W'(g))),
            .limit_i(limit_eff),
            .pend_o (pend[g]),
            .hit_o  (hit[g])
        );
    end

    cs_reconf_out #(.N_REQ(N_REQ)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .pulse_o(reconf_o),
        .idx_o  (reconf_idx_o)
    );

    assign pend_o     = pend;
    assign conflict_o = |pend;

    // R4
    pulse_from_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_o |-> $past(fail));

    // R9
    pulse_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_o |-> reconf_idx_o == $past(fail_idx));

endmodule

// File: tb/test_conflict_sense_monitor.sv
`timescale 1ns/1ps
module test_conflict_sense_monitor;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req, gnt;
    logic       cfg_wr;
    logic [7:0] cfg_slot;
    logic [3:0] cfg_limit;
    logic [3:0] pend;
    logic       conflict, reconf;
    logic [1:0] ridx;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    conflict_sense_monitor i_conflict_sense_monitor (
        .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_i(gnt),
        .cfg_wr_i(cfg_wr), .cfg_slot_i(cfg_slot), .cfg_limit_i(cfg_limit),
        .pend_o(pend), .conflict_o(conflict), .reconf_o(reconf),
        .reconf_idx_o(ridx)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; gnt = '0; cfg_wr = 1'b0;
        cfg_slot = '0; cfg_limit = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic write_cfg(input int l, input int m);
        cfg_wr = 1'b1; cfg_slot = 8'(l); cfg_limit = 4'(m);
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    // A lone requester j with slot l and limit m, run up to its first pulse.
    task automatic run_single(input int j, input int l, input int m, input bit load);
        int le, me, c0, cp;
        do_reset();
        if (load) write_cfg(l, m);
        le = (l == 0) ? 1 : l;
        me = (m == 0) ? 1 : m;
        c0 = le + ((j != 0) ? 1 : 0);
        cp = c0 + (me - 1) * le;
        req[j] = 1'b1;
        for (int c = 1; c <= cp; c++) begin
            @(negedge clk);
            chk("R2 pend", int'(pend), (c >= c0) ? (1 << j) : 0);
            chk("R6 conflict", int'(conflict), (c >= c0) ? 1 : 0);
            chk("R4 pulse", int'(reconf), (c == cp) ? 1 : 0);
            if (c == cp) chk("R9 index", int'(ridx), j);
        end
        @(negedge clk);
        chk("R4 single cycle", int'(reconf), (me == 1 && le == 1) ? 1 : 0);
    endtask

    initial begin
        do_reset();
        chk("R1 pend", int'(pend), 0);
        chk("R1 conflict", int'(conflict), 0);
        chk("R1 pulse", int'(reconf), 0);
        chk("R1 index", int'(ridx), 0);

        // R8: default slot 16 and limit 4, no configuration write.
        run_single(0, 16, 4, 1'b0);

        // R7: sweep loaded slot lengths, limits and requesters.
        for (int l = 1; l <= 4; l++)
            for (int m = 1; m <= 3; m++)
                for (int j = 0; j < 4; j++)
                    run_single(j, l, m, 1'b1);

        // R7: zero values behave as one.
        run_single(0, 0, 0, 1'b1);
        run_single(3, 0, 2, 1'b1);

        // R3: rotation between requesters 0 and 2, slot 3, limit 2.
        do_reset();
        write_cfg(3, 2);
        req = 4'b0101;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            chk("R3 pend0", int'(pend[0]), (c >= 3) ? 1 : 0);
            chk("R3 pend2", int'(pend[2]), (c >= 6) ? 1 : 0);
            chk("R4 rot pulse", int'(reconf), (c == 9 || c == 12) ? 1 : 0);
            if (c == 9)  chk("R9 rot index", int'(ridx), 0);
            if (c == 12) chk("R9 rot index", int'(ridx), 2);
        end
        // R5: a withdrawn request clears its pending flag.
        req[2] = 1'b0;
        @(negedge clk);
        chk("R5 withdraw", int'(pend), 1);
        chk("R6 still pending", int'(conflict), 1);

        // R5: a grant in mid-run clears the count; slot 3, limit 3.
        do_reset();
        write_cfg(3, 3);
        req[0] = 1'b1;
        repeat (7) @(negedge clk);
        chk("R2 before grant", int'(pend), 1);
        gnt[0] = 1'b1;
        @(negedge clk);
        gnt[0] = 1'b0;
        chk("R5 grant clears", int'(pend), 0);
        for (int c = 9; c <= 17; c++) begin
            @(negedge clk);
            chk("R5 regrow pend", int'(pend), (c >= 11) ? 1 : 0);
            chk("R5 restart pulse", int'(reconf), (c == 17) ? 1 : 0);
        end

        // R5: a grant on the expiry edge prevents the failure.
        do_reset();
        write_cfg(3, 1);
        req[0] = 1'b1;
        repeat (2) @(negedge clk);
        gnt[0] = 1'b1;
        @(negedge clk);
        gnt[0] = 1'b0;
        chk("R5 same edge pend", int'(pend), 0);
        chk("R5 same edge pulse", int'(reconf), 0);
        for (int c = 4; c <= 6; c++) begin
            @(negedge clk);
            chk("R5 late fail", int'(pend), (c >= 6) ? 1 : 0);
            chk("R5 late pulse", int'(reconf), (c == 6) ? 1 : 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule